// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

A register-mapped mailbox block that lets several processors pass short messages to each other. It has a number of independent channels. Each channel holds an owner, a destination set, a mode and state field, an interrupt mask, a pending-interrupt vector and a small bank of 32-bit data words. Processors are identified by one-hot source IDs. Every bus write carries the writer's ID inside the data word.

To send a message, a processor claims an idle channel by writing its ID to the owner register and reading it back. It then fills in the destinations and data words and writes its ID to the send register. Each destination gets an interrupt. The channel then moves to the acknowledged state, either at once in auto-answer mode or after the destinations clear their interrupts. The sender sees the acknowledge in the mode register, clears its own interrupt and writes its ID to the owner register again to free the channel.

All writes are blocked until a key has been written to a global lock register.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the block is locked, and the lock register at byte address 0xA00 reads 1. Writing 0x1ACCE551 there unlocks it, so the register reads 0. Writing any other value there locks it again. While the block is locked, writes to every other address are ignored.
- R2: Channel c occupies the 64-byte window starting at c*0x40. Data word d sits at window offset 0x20+4*d, resets to 0 and reads back the last value written to it.
- R3: The mode register at window offset 0x10 reads {state[3:0], 3'b0, auto}. The state codes are idle 0x1, claimed 0x2, sent 0x4 and acknowledged 0x8, so an idle channel reads exactly 0x10. Writes to the mode register while the channel is idle are ignored.
- R4: Writing a one-hot ID to the owner register (offset 0x00) of an idle channel stores that ID and moves the channel to claimed, so mode reads 0x20. A value that is not one-hot, or that has bits above the source width, is ignored.
- R5: While a channel is claimed, a write to its owner register with any value other than the owner's ID leaves the owner unchanged.
- R6: Writing the owner's own ID to the owner register of a non-idle channel frees it. Afterwards the owner reads 0, mode reads 0x10 and the destination set reads 0.
- R7: A write to offset 0x04 ORs bits into the destination set. A write to offset 0x08 clears the written bits. Offset 0x0C reads the destination set.
- R8: A write to the send register (offset 0x1C) with the owner's ID, while the channel is claimed, sets a pending bit for every destination. irq_o[s] is the OR over all channels of pending[s] AND NOT mask[s]. A send write carrying any other value, or made in another state, is ignored.
- R9: The interrupt mask at offset 0x14 resets to all ones, meaning every source is masked. A masked source's pending bit stays set and can be read at offset 0x18, but it does not drive irq_o.
- R10: A write to offset 0x18 clears the pending bits that are set in the written value.
- R11: With mode bit 0 set (auto-answer), a valid send moves the channel straight to acknowledged, so mode reads 0x81 right after the write edge. The same write also sets the owner's pending bit.
- R12: With auto-answer off, a valid send moves the channel to sent (mode 0x40). One clock edge after no destination pending bit remains, the channel moves to acknowledged (mode 0x80) and the owner's pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | NUM_SRC | Interrupt per source |

## Verification
Register writes take effect on the clock edge at which they are presented. Read data is combinational from addr_i, so every write result is sampled one time step after that edge and before the next one. The auto-answer acknowledge lands on the same edge as the send. The manual acknowledge lands exactly one edge after the last destination pending bit is cleared. The bench checks the mode value both right after the clearing edge (still 0x40) and one cycle later (0x80). irq_o follows pending and mask registers with no further register stage, so it is checked in the same time slot as the register read-back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [31:0] UNLOCK_KEY  = 32'h1ACCE551;
  localparam int          LOCK_OFFSET = 'hA00;

  // word index inside a 64-byte channel window
  localparam logic [3:0] W_OWNER = 4'd0;
  localparam logic [3:0] W_DSET  = 4'd1;
  localparam logic [3:0] W_DCLR  = 4'd2;
  localparam logic [3:0] W_DSTAT = 4'd3;
  localparam logic [3:0] W_MODE  = 4'd4;
  localparam logic [3:0] W_IMASK = 4'd5;
  localparam logic [3:0] W_ICLR  = 4'd6;
  localparam logic [3:0] W_SEND  = 4'd7;
  localparam int         W_DATA  = 8;

  typedef enum logic [3:0] {
    ST_IDLE = 4'h1,
    ST_BUSY = 4'h2,
    ST_SENT = 4'h4,
    ST_ACK  = 4'h8
  } ch_state_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode import mbox_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - 6
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              unlocked_i,
  output logic [NUM_CH-1:0] ch_we_o,
  output logic              ch_hit_o,
  output logic [IDX_W-1:0]  ch_idx_o,
  output logic [3:0]        word_o,
  output logic              lock_hit_o,
  output logic              lock_we_o
);
  logic aligned;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign ch_idx_o   = addr_i[ADDR_W-1:6];
  assign word_o     = addr_i[5:2];
  assign ch_hit_o   = aligned && (32'(ch_idx_o) < 32'(NUM_CH));
  assign lock_hit_o = (addr_i == ADDR_W'(LOCK_OFFSET));
  assign lock_we_o  = req_i && we_i && lock_hit_o;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign ch_we_o[c] = req_i && we_i && unlocked_i && ch_hit_o &&
                        (ch_idx_o == IDX_W'(c));
  end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan import mbox_pkg::*; #(
  parameter int NUM_SRC  = 6,
  parameter int NUM_DATA = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [3:0]         word_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SRC-1:0] irq_o,
  output logic [NUM_SRC-1:0] owner_o
);
  ch_state_e          state_q, state_d;
  logic               auto_q, auto_d;
  logic [NUM_SRC-1:0] owner_q, owner_d, dest_q, dest_d;
  logic [NUM_SRC-1:0] mask_q, mask_d, pend_q, pend_d;
  logic [31:0]        data_q [NUM_DATA];

  logic [NUM_SRC-1:0] src_w;
  logic               id_ok, is_owner;

  assign src_w    = wdata_i[NUM_SRC-1:0];
  assign id_ok    = ((wdata_i >> NUM_SRC) == '0);
  assign is_owner = (state_q != ST_IDLE) && id_ok && (src_w == owner_q);

  always_comb begin
    state_d = state_q;
    auto_d  = auto_q;
    owner_d = owner_q;
    dest_d  = dest_q;
    mask_d  = mask_q;
    pend_d  = pend_q;
    // manual answer: ack once every destination has taken its interrupt
    if (state_q == ST_SENT && (pend_q & dest_q) == '0) begin
      state_d = ST_ACK;
      pend_d  = pend_q | owner_q;
    end
    if (we_i) begin
      case (word_i)
        W_OWNER: begin
          if (state_q == ST_IDLE && id_ok && $onehot(src_w)) begin
            owner_d = src_w;
            state_d = ST_BUSY;
          end else if (is_owner) begin
            owner_d = '0;
            state_d = ST_IDLE;
            auto_d  = 1'b0;
            dest_d  = '0;
          end
        end
        W_DSET:  dest_d = dest_q | src_w;
        W_DCLR:  dest_d = dest_q & ~src_w;
        W_MODE:  if (state_q != ST_IDLE) auto_d = wdata_i[0];
        W_IMASK: mask_d = src_w;
        W_ICLR:  pend_d = pend_d & ~src_w;
        W_SEND: begin
          if (state_q == ST_BUSY && is_owner) begin
            pend_d  = pend_d | dest_q | (auto_q ? owner_q : '0);
            state_d = auto_q ? ST_ACK : ST_SENT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      auto_q  <= 1'b0;
      owner_q <= '0;
      dest_q  <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
      owner_q <= owner_d;
      dest_q  <= dest_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
    end
  end

  for (genvar d = 0; d < NUM_DATA; d++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  data_q[d] <= '0;
      else if (we_i && word_i == 4'(W_DATA + d))    data_q[d] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (word_i)
      W_OWNER: rdata_o = 32'(owner_q);
      W_DSTAT: rdata_o = 32'(dest_q);
      W_MODE:  rdata_o = {24'b0, state_q, 3'b0, auto_q};
      W_IMASK: rdata_o = 32'(mask_q);
      W_ICLR:  rdata_o = 32'(pend_q);
      default: ;
    endcase
    for (int d = 0; d < NUM_DATA; d++)
      if (word_i == 4'(W_DATA + d)) rdata_o = data_q[d];
  end

  assign irq_o   = pend_q & ~mask_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl import mbox_pkg::*; #(
  parameter int NUM_CH   = 4,
  parameter int NUM_SRC  = 6,
  parameter int NUM_DATA = 2,
  parameter int ADDR_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SRC-1:0] irq_o
);
  localparam int IDX_W = ADDR_W - 6;

  logic                      unlocked_q;
  logic [NUM_CH-1:0]         ch_we;
  logic                      ch_hit, lock_hit, lock_we;
  logic [IDX_W-1:0]          ch_idx;
  logic [3:0]                word;
  logic [31:0]               ch_rdata [NUM_CH];
  logic [NUM_SRC-1:0]        ch_irq   [NUM_CH];
  logic [NUM_SRC-1:0]        ch_owner [NUM_CH];
  logic [NUM_CH*NUM_SRC-1:0] owner_flat;

  mbox_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .unlocked_i (unlocked_q),
    .ch_we_o    (ch_we),
    .ch_hit_o   (ch_hit),
    .ch_idx_o   (ch_idx),
    .word_o     (word),
    .lock_hit_o (lock_hit),
    .lock_we_o  (lock_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      unlocked_q <= 1'b0;
    else if (lock_we) unlocked_q <= (wdata_i == UNLOCK_KEY);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbox_chan #(.NUM_SRC(NUM_SRC), .NUM_DATA(NUM_DATA)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ch_we[c]),
      .word_i  (word),
      .wdata_i (wdata_i),
      .rdata_o (ch_rdata[c]),
      .irq_o   (ch_irq[c]),
      .owner_o (ch_owner[c])
    );
    assign owner_flat[c*NUM_SRC +: NUM_SRC] = ch_owner[c];
  end

  always_comb begin
    irq_o   = '0;
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      irq_o = irq_o | ch_irq[c];
      if (ch_hit && ch_idx == IDX_W'(c)) rdata_o = ch_rdata[c];
    end
    if (lock_hit) rdata_o = {31'b0, ~unlocked_q};
  end
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk import mbox_pkg::*; #(
  parameter int NUM_CH  = 4,
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 12
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [31:0]               wdata_i,
  input logic                      unlocked_i,
  input logic [NUM_CH*NUM_SRC-1:0] owner_flat_i
);
  logic lock_wr;
  assign lock_wr = req_i && we_i && (addr_i == ADDR_W'(LOCK_OFFSET));

  AST_KEY_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_wr && wdata_i == UNLOCK_KEY |=> unlocked_i); // R1
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_wr && wdata_i != UNLOCK_KEY |=> !unlocked_i); // R1
  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i && req_i && we_i && !lock_wr |=> $stable(owner_flat_i)); // R1

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [NUM_SRC-1:0] own;
    logic               own_wr;
    assign own    = owner_flat_i[c*NUM_SRC +: NUM_SRC];
    assign own_wr = unlocked_i && req_i && we_i && addr_i[1:0] == 2'b00 &&
                    addr_i[ADDR_W-1:6] == (ADDR_W-6)'(c) && addr_i[5:2] == 4'd0;

    AST_OWNER_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(own)); // R4
    AST_NO_STEAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_wr && own != '0 && wdata_i != 32'(own) |=> $stable(own)); // R5
    AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_wr && own != '0 && wdata_i == 32'(own) |=> own == '0); // R6
  end
endmodule

bind mbox_ctrl mbox_ctrl_chk #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .unlocked_i   (unlocked_q),
  .owner_flat_i (owner_flat)
);

// File: tb/mbox_ctrl_test.sv
module mbox_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 6;
  localparam logic [11:0] LOCK = 12'hA00;
  localparam logic [31:0] KEY  = 32'h1ACCE551;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0, we_i = 1'b0;
  logic [11:0]     addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic [NSRC-1:0] irq_o;
  int checks = 0, fails = 0;

  mbox_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] ca(input int ch, input int off);
    return 12'(ch*64 + off);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 reset irq", 32'(irq_o), 0);
    rd(LOCK, v);        chk("R1 reset locked", v, 1);
    rd(ca(0,16), v);    chk("R3 reset mode idle", v, 32'h10);
    rd(ca(0,20), v);    chk("R9 reset mask", v, 32'h3F);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(ca(0,36), 32'hDEADBEEF);
    rd(ca(0,36), v);    chk("R1 locked write ignored", v, 0);
    wr(LOCK, 32'h1ACCE550);
    rd(LOCK, v);        chk("R1 wrong key", v, 1);
    wr(LOCK, KEY);
    rd(LOCK, v);        chk("R1 key unlocks", v, 0);
    wr(ca(0,36), 32'hDEADBEEF);
    rd(ca(0,36), v);    chk("R2 data word1 ch0", v, 32'hDEADBEEF);
    wr(ca(1,32), 32'h12345678);
    rd(ca(1,32), v);    chk("R2 data word0 ch1", v, 32'h12345678);
    rd(ca(0,32), v);    chk("R2 data word0 ch0 untouched", v, 0);
    wr(LOCK, 32'h0);
    rd(LOCK, v);        chk("R1 relock", v, 1);
    wr(ca(1,32), 32'hFFFF0000);
    rd(ca(1,32), v);    chk("R1 relocked write ignored", v, 32'h12345678);
    wr(LOCK, KEY);
  endtask

  task automatic t_claim();
    logic [31:0] v;
    wr(ca(1,0), 32'h3);
    rd(ca(1,0), v);     chk("R4 non-onehot ignored", v, 0);
    wr(ca(1,0), 32'h40);
    rd(ca(1,0), v);     chk("R4 out-of-range id ignored", v, 0);
    wr(ca(1,16), 32'h1);
    rd(ca(1,16), v);    chk("R3 idle mode write ignored", v, 32'h10);
    wr(ca(1,0), 32'h2);
    rd(ca(1,0), v);     chk("R4 claim owner", v, 32'h2);
    rd(ca(1,16), v);    chk("R4 claimed mode", v, 32'h20);
    wr(ca(1,0), 32'h1);
    rd(ca(1,0), v);     chk("R5 steal ignored", v, 32'h2);
    wr(ca(1,4), 32'h10);
    wr(ca(1,0), 32'h2);
    rd(ca(1,0), v);     chk("R6 release owner", v, 0);
    rd(ca(1,16), v);    chk("R6 release mode", v, 32'h10);
    rd(ca(1,12), v);    chk("R6 release dest", v, 0);
  endtask

  task automatic t_auto();
    logic [31:0] v;
    wr(ca(2,0), 32'h1);
    wr(ca(2,16), 32'h1);
    rd(ca(2,16), v);    chk("R11 auto mode set", v, 32'h21);
    wr(ca(2,20), 32'h36);
    wr(ca(2,4), 32'h8);
    wr(ca(2,4), 32'h2);
    rd(ca(2,12), v);    chk("R7 dest set", v, 32'hA);
    wr(ca(2,8), 32'h2);
    rd(ca(2,12), v);    chk("R7 dest clear", v, 32'h8);
    chk("R8 no irq before send", 32'(irq_o), 0);
    wr(ca(2,28), 32'h1);
    rd(ca(2,16), v);    chk("R11 auto ack", v, 32'h81);
    chk("R8 irq dest+owner", 32'(irq_o), 32'h09);
    rd(ca(2,24), v);    chk("R9 pending read", v, 32'h09);
    wr(ca(2,24), 32'h8);
    chk("R10 clear dest irq", 32'(irq_o), 32'h01);
    wr(ca(2,24), 32'h1);
    chk("R10 clear owner irq", 32'(irq_o), 0);
    wr(ca(2,0), 32'h1);
    rd(ca(2,16), v);    chk("R6 release after ack", v, 32'h10);
  endtask

  task automatic t_manual();
    logic [31:0] v;
    wr(ca(3,0), 32'h4);
    wr(ca(3,20), 32'h0);
    wr(ca(3,4), 32'h10);
    wr(ca(3,28), 32'h1);
    rd(ca(3,16), v);    chk("R8 send by non-owner ignored", v, 32'h20);
    chk("R8 no irq after bad send", 32'(irq_o), 0);
    wr(ca(3,28), 32'h4);
    rd(ca(3,16), v);    chk("R12 sent state", v, 32'h40);
    chk("R8 dest irq", 32'(irq_o), 32'h10);
    wr(ca(3,20), 32'h10);
    chk("R9 masked irq", 32'(irq_o), 0);
    rd(ca(3,24), v);    chk("R9 masked pending kept", v, 32'h10);
    wr(ca(3,24), 32'h10);
    rd(ca(3,16), v);    chk("R12 still sent on clear edge", v, 32'h40);
    @(posedge clk); #1;
    rd(ca(3,16), v);    chk("R12 ack one cycle later", v, 32'h80);
    chk("R12 owner irq", 32'(irq_o), 32'h04);
    wr(ca(3,28), 32'h4);
    rd(ca(3,24), v);    chk("R8 send in ack state ignored", v, 32'h04);
    wr(ca(3,24), 32'h4);
    wr(ca(3,0), 32'h4);
    rd(ca(3,16), v);    chk("R6 manual release", v, 32'h10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_lock();
    t_claim();
    t_auto();
    t_manual();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule